// File: doc/BRIEF.md
# Synchronous Host Burst-Write Slave Port

This block sits on a shared external host bus and takes in synchronous burst writes aimed at one device among several. On the first rising clock edge that sees chip select, it captures the access header: byte address, destination field, device identifier, read/write flag and burst flag. It claims the access only when the identifier matches a configured value and the access is a burst write. Otherwise it leaves the cycle alone and never drives the acknowledge line.

Once it has claimed an access, the port paces the host one beat at a time with an active-low acknowledge. Each beat whose edge sees the acknowledge active is pushed into an internal write buffer, together with its computed address, destination and byte enables. While the buffer is full, the acknowledge is withheld. A burst is four beats on a 64-bit data bus and eight beats on a 32-bit data bus. After the last beat the port drives the acknowledge inactive-high for one cycle and then stops driving it. The host may start another access on the edge that follows the last beat, without dropping chip select. The acknowledge is modelled as a value output plus an output-enable, not as a true tristate. The internal side drains the buffer through a simple pop port.

Top module: `hbw_slave`

## Requirements
- R1: A synchronous active-low reset puts the port in idle: ack_oe_o=0, ack_n_o=1 and the buffer empty (pop_valid_o=0).
- R2: An access whose host_id differs from cfg_id is ignored: ack_oe_o stays 0 and no entry reaches the buffer.
- R3: Only host_burst=1 with host_rd=0 (1 means read, 0 means write) is claimed. Reads and single accesses with a matching id are ignored in the same way as in R2.
- R4: The header is captured on the first rising edge with host_cs=1. From the next cycle ack_oe_o=1, and ack_n_o=0 whenever the buffer is not full. Each edge with ack_n_o=0 pushes the current host_data/host_be as one beat.
- R5: While the buffer holds FIFO_DEPTH entries (buf_full_o=1), ack_n_o stays 1 and the host's beat is held.
- R6: A claimed burst has 4 beats when cfg_wide=1 (64-bit bus) and 8 beats when cfg_wide=0 (32-bit bus). cfg_wide is sampled at the capture edge.
- R7: In the cycle after the last beat, ack_oe_o=1 and ack_n_o=1. In the following cycle ack_oe_o=0, unless a new access was captured.
- R8: A new claimed access presented on the edge right after the last beat is captured, with host_cs held high throughout.
- R9: Beat k of a burst is stored with address A + k*8 (wide mode) or A + k*4 (narrow mode), where A is the captured host_addr. Each entry also carries the captured destination field and that beat's byte enables.
- R10: In narrow mode, data bits 63:32 and byte enables 7:4 are stored as zero.
- R11: pop_valid_o=1 whenever the buffer is non-empty, and the pop outputs show the oldest entry. pop_i removes that entry. pop_i on an empty buffer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_id | input | 4 | Identifier this device answers to |
| cfg_wide | input | 1 | 1: 64-bit data bus, 0: 32-bit data bus |
| host_cs | input | 1 | Chip select, active high |
| host_id | input | 4 | Device identifier of the access |
| host_rd | input | 1 | 1 read, 0 write |
| host_burst | input | 1 | Burst indicator |
| host_addr | input | 20 | Start byte address |
| host_dst | input | 2 | Destination field |
| host_data | input | 64 | Write data |
| host_be | input | 8 | Byte enables |
| ack_n_o | output | 1 | Acknowledge value, active low |
| ack_oe_o | output | 1 | Acknowledge output enable |
| buf_full_o | output | 1 | Write buffer full |
| pop_i | input | 1 | Remove oldest buffer entry |
| pop_valid_o | output | 1 | Buffer not empty |
| pop_addr_o | output | 20 | Oldest entry address |
| pop_dst_o | output | 2 | Oldest entry destination |
| pop_be_o | output | 8 | Oldest entry byte enables |
| pop_data_o | output | 64 | Oldest entry data |

## Verification
Single wide and narrow bursts with random data show that the beat count and the address step follow the mode. Narrow data with nonzero upper halves shows the masking. Accesses with a wrong id, with the read flag set, or without the burst flag must all leave the acknowledge undriven and the buffer empty, which separates the three decode terms. Back-to-back bursts with chip select held high, first wide then narrow, separate the release cycle from a restart. A burst issued while the drain is stopped fills the buffer and must stall until popping resumes. The drain pops at random, including on an empty buffer.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    localparam int HBW_AW          = 20;
    localparam int HBW_DW          = 64;
    localparam int HBW_BW          = HBW_DW / 8;
    localparam int HBW_IDW         = 4;
    localparam int HBW_DSTW        = 2;
    localparam int HBW_BURST_BYTES = 32;

    typedef struct packed {
        logic [HBW_AW-1:0]   addr;
        logic [HBW_DSTW-1:0] dst;
        logic [HBW_BW-1:0]   be;
        logic [HBW_DW-1:0]   data;
    } hbw_entry_t;

    typedef enum logic [1:0] {
        HBW_IDLE  = 2'd0,
        HBW_BURST = 2'd1,
        HBW_REL   = 2'd2
    } hbw_state_e;
endpackage

// File: rtl/hbw_fifo.sv
module hbw_fifo
    import hbw_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  hbw_entry_t push_entry_i,
    input  logic       pop_i,
    output logic       full_o,
    output logic       valid_o,
    output hbw_entry_t head_o
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW:0] wr;
        logic [PW:0] rd;
    } fifo_state_t;

    fifo_state_t q, d;
    hbw_entry_t  mem_q [DEPTH];
    logic        empty, do_push, do_pop;

    always_comb begin
        empty   = (q.wr == q.rd);
        full_o  = (q.wr[PW] != q.rd[PW]) && (q.wr[PW-1:0] == q.rd[PW-1:0]);
        valid_o = !empty;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty;
        head_o  = mem_q[q.rd[PW-1:0]];
        d = q;
        if (do_push) d.wr = q.wr + 1'b1;
        if (do_pop)  d.rd = q.rd + 1'b1;
        if (!rst_n)  d = '0;
    end

    always_ff @(posedge clk) begin
        q <= d;
        if (do_push) mem_q[q.wr[PW-1:0]] <= push_entry_i;
    end

    // R5: the controller never offers a beat into a full buffer
    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R11: popping an empty buffer leaves it empty
    a_r11_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !valid_o && !push_i) |=> !valid_o);
endmodule

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
    import hbw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HBW_IDW-1:0]  cfg_id,
    input  logic                cfg_wide,
    input  logic                host_cs,
    input  logic [HBW_IDW-1:0]  host_id,
    input  logic                host_rd,
    input  logic                host_burst,
    input  logic [HBW_AW-1:0]   host_addr,
    input  logic [HBW_DSTW-1:0] host_dst,
    input  logic [HBW_DW-1:0]   host_data,
    input  logic [HBW_BW-1:0]   host_be,
    input  logic                buf_full_i,
    output logic                ack_n_o,
    output logic                ack_oe_o,
    output logic                push_o,
    output hbw_entry_t          push_entry_o
);
    localparam int BEATS_WIDE   = HBW_BURST_BYTES / HBW_BW;
    localparam int BEATS_NARROW = 2 * BEATS_WIDE;
    localparam int CW           = $clog2(BEATS_NARROW);
    localparam int HALF_DW      = HBW_DW / 2;
    localparam int HALF_BW      = HBW_BW / 2;

    typedef struct packed {
        hbw_state_e          st;
        logic [CW-1:0]       cnt;
        logic [HBW_AW-1:0]   addr;
        logic                wide;
        logic [HBW_DSTW-1:0] dst;
    } ctrl_state_t;

    ctrl_state_t       q, d;
    logic              start, beat_ok;
    logic [CW-1:0]     last_cnt;
    logic [HBW_AW-1:0] step;

    always_comb begin
        start    = host_cs && (host_id == cfg_id) && host_burst && !host_rd;
        beat_ok  = (q.st == HBW_BURST) && !buf_full_i;
        last_cnt = q.wide ? CW'(BEATS_WIDE - 1) : CW'(BEATS_NARROW - 1);
        step     = q.wide ? HBW_AW'(HBW_BW) : HBW_AW'(HALF_BW);

        ack_n_o  = !beat_ok;
        ack_oe_o = (q.st != HBW_IDLE);
        push_o   = beat_ok;

        push_entry_o.addr = q.addr;
        push_entry_o.dst  = q.dst;
        push_entry_o.data = q.wide ? host_data : {{HALF_DW{1'b0}}, host_data[HALF_DW-1:0]};
        push_entry_o.be   = q.wide ? host_be   : {{HALF_BW{1'b0}}, host_be[HALF_BW-1:0]};

        d = q;
        unique case (q.st)
            HBW_IDLE, HBW_REL: begin
                if (start) begin
                    d.st   = HBW_BURST;
                    d.cnt  = '0;
                    d.addr = host_addr;
                    d.wide = cfg_wide;
                    d.dst  = host_dst;
                end else begin
                    d.st = HBW_IDLE;
                end
            end
            HBW_BURST: begin
                if (beat_ok) begin
                    d.cnt  = q.cnt + 1'b1;
                    d.addr = q.addr + step;
                    if (q.cnt == last_cnt) d.st = HBW_REL;
                end
            end
            default: d.st = HBW_IDLE;
        endcase
        if (!rst_n) begin
            d    = '0;
            d.st = HBW_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    // R1: reset leaves the acknowledge undriven
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!ack_oe_o && ack_n_o));

    // R2 / R3: without a claimed access the acknowledge never goes active
    a_r2_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != HBW_BURST) && !start) |=> ack_n_o);

    // R4: an active acknowledge is always driven
    a_r4_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_o |-> ack_oe_o);

    // R7: one driven-high cycle after the last beat
    a_r7_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && (q.cnt == last_cnt)) |=> (ack_oe_o && ack_n_o));

    // R7: release ends with the driver off when nothing new starts
    a_r7_release_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == HBW_REL) && !start) |=> !ack_oe_o);

    // R8: a restart during the release cycle is taken
    a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == HBW_REL) && start) |=> (ack_oe_o && (q.st == HBW_BURST)));
endmodule

// File: rtl/hbw_slave.sv
module hbw_slave
    import hbw_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HBW_IDW-1:0]  cfg_id,
    input  logic                cfg_wide,
    input  logic                host_cs,
    input  logic [HBW_IDW-1:0]  host_id,
    input  logic                host_rd,
    input  logic                host_burst,
    input  logic [HBW_AW-1:0]   host_addr,
    input  logic [HBW_DSTW-1:0] host_dst,
    input  logic [HBW_DW-1:0]   host_data,
    input  logic [HBW_BW-1:0]   host_be,
    output logic                ack_n_o,
    output logic                ack_oe_o,
    output logic                buf_full_o,
    input  logic                pop_i,
    output logic                pop_valid_o,
    output logic [HBW_AW-1:0]   pop_addr_o,
    output logic [HBW_DSTW-1:0] pop_dst_o,
    output logic [HBW_BW-1:0]   pop_be_o,
    output logic [HBW_DW-1:0]   pop_data_o
);
    logic       push;
    hbw_entry_t push_entry, head;

    hbw_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_id       (cfg_id),
        .cfg_wide     (cfg_wide),
        .host_cs      (host_cs),
        .host_id      (host_id),
        .host_rd      (host_rd),
        .host_burst   (host_burst),
        .host_addr    (host_addr),
        .host_dst     (host_dst),
        .host_data    (host_data),
        .host_be      (host_be),
        .buf_full_i   (buf_full_o),
        .ack_n_o      (ack_n_o),
        .ack_oe_o     (ack_oe_o),
        .push_o       (push),
        .push_entry_o (push_entry)
    );

    hbw_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .push_entry_i (push_entry),
        .pop_i        (pop_i),
        .full_o       (buf_full_o),
        .valid_o      (pop_valid_o),
        .head_o       (head)
    );

    assign pop_addr_o = head.addr;
    assign pop_dst_o  = head.dst;
    assign pop_be_o   = head.be;
    assign pop_data_o = head.data;
endmodule

// File: tb/test_hbw_slave.sv
module test_hbw_slave;
    import hbw_pkg::*;

    localparam int DEPTH = 8;

    logic        clk = 0, rst_n = 0;
    logic [3:0]  cfg_id = 4'h5;
    logic        cfg_wide = 1;
    logic        host_cs = 0, host_rd = 0, host_burst = 0;
    logic [3:0]  host_id = 0;
    logic [19:0] host_addr = 0;
    logic [1:0]  host_dst = 0;
    logic [63:0] host_data = 0;
    logic [7:0]  host_be = 0;
    logic        pop = 0, pop_en = 1;
    logic        ack_n_o, ack_oe_o, buf_full_o, pop_valid_o;
    logic [19:0] pop_addr_o;
    logic [1:0]  pop_dst_o;
    logic [7:0]  pop_be_o;
    logic [63:0] pop_data_o;

    int    n_tests = 0, n_fail = 0;
    string ph = "R1";

    hbw_slave #(.FIFO_DEPTH(DEPTH)) i_hbw_slave (
        .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id), .cfg_wide(cfg_wide),
        .host_cs(host_cs), .host_id(host_id), .host_rd(host_rd),
        .host_burst(host_burst), .host_addr(host_addr), .host_dst(host_dst),
        .host_data(host_data), .host_be(host_be),
        .ack_n_o(ack_n_o), .ack_oe_o(ack_oe_o), .buf_full_o(buf_full_o),
        .pop_i(pop), .pop_valid_o(pop_valid_o), .pop_addr_o(pop_addr_o),
        .pop_dst_o(pop_dst_o), .pop_be_o(pop_be_o), .pop_data_o(pop_data_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 burst, 2 release
    int         m_st = 0, m_cnt = 0, m_wide = 1;
    logic [19:0] m_addr = 0;
    logic [1:0]  m_dst = 0;
    hbw_entry_t  m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            m_q.delete();
        end else begin
            int  sz;
            bit  acc, start;
            hbw_entry_t e;
            sz    = m_q.size();
            acc   = (m_st == 1) && (sz < DEPTH);
            start = host_cs && host_id == cfg_id && host_burst && !host_rd;
            if (pop && sz > 0) void'(m_q.pop_front());
            if (acc) begin
                e.addr = m_addr;
                e.dst  = m_dst;
                e.data = m_wide != 0 ? host_data : {32'h0, host_data[31:0]};
                e.be   = m_wide != 0 ? host_be   : {4'h0, host_be[3:0]};
                m_q.push_back(e);
            end
            if (m_st == 1) begin
                if (acc) begin
                    m_cnt++;
                    m_addr = m_addr + (m_wide != 0 ? 20'd8 : 20'd4);
                    if (m_cnt == (m_wide != 0 ? 4 : 8)) m_st = 2;
                end
            end else if (start) begin
                m_st = 1; m_cnt = 0; m_addr = host_addr;
                m_wide = cfg_wide; m_dst = host_dst;
            end else begin
                m_st = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_ack;
            exp_ack = (m_st == 1) && (m_q.size() < DEPTH);
            chk(ack_oe_o == (m_st != 0), m_st == 2 ? "R7" : ph, "ack_oe",
                64'(ack_oe_o), 64'(m_st != 0));
            chk(ack_n_o == !exp_ack, (m_st == 1 && !exp_ack) ? "R5" : ph, "ack_n",
                64'(ack_n_o), 64'(!exp_ack));
            chk(pop_valid_o == (m_q.size() > 0), "R11", "pop_valid",
                64'(pop_valid_o), 64'(m_q.size() > 0));
            if (m_q.size() > 0) begin
                chk(pop_addr_o == m_q[0].addr && pop_dst_o == m_q[0].dst, "R9",
                    "addr/dst", {42'h0, pop_dst_o, pop_addr_o},
                    {42'h0, m_q[0].dst, m_q[0].addr});
                chk(pop_data_o == m_q[0].data, ph == "R10" ? "R10" : "R9", "data",
                    pop_data_o, m_q[0].data);
                chk(pop_be_o == m_q[0].be, ph == "R10" ? "R10" : "R9", "be",
                    64'(pop_be_o), 64'(m_q[0].be));
            end
        end
        pop = pop_en && ($urandom_range(0, 2) != 0);
    end

    // host side; entered and left at a negedge, host_cs left as is
    task automatic access(input logic [3:0] id, input logic [19:0] a, input logic wide,
                          input logic rd, input logic bst, input bit claim);
        int  beats, k;
        bit  acked;
        cfg_wide   = wide;
        host_cs    = 1; host_id = id; host_addr = a; host_rd = rd; host_burst = bst;
        host_dst   = 2'($urandom);
        host_data  = {$urandom, $urandom};
        host_be    = 8'($urandom);
        if (!claim) begin
            @(negedge clk);
            host_cs = 0;
            repeat (3) @(negedge clk);
            return;
        end
        beats = wide ? 4 : 8;
        k = 0;
        @(negedge clk);
        while (k < beats) begin
            acked = !ack_n_o;
            @(negedge clk);
            if (acked) begin
                k++;
                if (k < beats) begin
                    host_data = {$urandom, $urandom};
                    host_be   = 8'($urandom);
                end
            end
        end
        chk(k == beats, wide ? "R6" : "R6", "beats", 64'(k), 64'(beats));
        chk(ack_oe_o && ack_n_o, "R7", "release cycle", {62'h0, ack_oe_o, ack_n_o}, 64'h3);
    endtask

    task automatic idle(input int n);
        host_cs = 0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        ph = "R1";
        chk(!ack_oe_o && ack_n_o && !pop_valid_o, "R1", "reset state",
            {61'h0, ack_oe_o, ack_n_o, pop_valid_o}, 64'h2);
        rst_n = 1;
        @(negedge clk);

        ph = "R4";  access(4'h5, 20'h01000, 1, 0, 1, 1); idle(12);
        ph = "R10"; access(4'h5, 20'h02004, 0, 0, 1, 1); idle(14);
        ph = "R2";  access(4'h9, 20'h03000, 1, 0, 1, 0);
        chk(!pop_valid_o && !ack_oe_o, "R2", "id mismatch ignored",
            {62'h0, pop_valid_o, ack_oe_o}, 64'h0);
        ph = "R3";  access(4'h5, 20'h04000, 1, 1, 1, 0);
        access(4'h5, 20'h05000, 1, 0, 0, 0);
        chk(!pop_valid_o && !ack_oe_o, "R3", "read/single ignored",
            {62'h0, pop_valid_o, ack_oe_o}, 64'h0);

        ph = "R8";
        access(4'h5, 20'h06000, 1, 0, 1, 1);
        access(4'h5, 20'h07010, 0, 0, 1, 1);
        access(4'h5, 20'h08000, 1, 0, 1, 1);
        idle(20);

        ph = "R5";
        pop_en = 0;
        @(negedge clk);
        access(4'h5, 20'h09000, 1, 0, 1, 1);
        access(4'h5, 20'h0A000, 1, 0, 1, 1);
        fork
            access(4'h5, 20'h0B000, 1, 0, 1, 1);
            begin
                repeat (10) @(negedge clk);
                chk(buf_full_o && ack_n_o && ack_oe_o, "R5", "stall while full",
                    {61'h0, buf_full_o, ack_n_o, ack_oe_o}, 64'h7);
                pop_en = 1;
            end
        join
        idle(40);

        ph = "R11";
        chk(!pop_valid_o, "R11", "drained", 64'(pop_valid_o), 64'h0);
        idle(10);

        ph = "R1";
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!ack_oe_o && !pop_valid_o, "R1", "reset again",
            {62'h0, ack_oe_o, pop_valid_o}, 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule